// File: doc/BRIEF.md
# Nine-Channel Sigma-Delta Integrator Bank

This block receives nine single-bit sigma-delta modulator streams and runs each through a chain of three cascaded integrators. Together these integrators form the integrating half of a third-order sinc filter. The comb stages and any decimation arithmetic are left to software. Each channel chooses which of four modulator clock inputs it follows, and whether the rising or the falling edge of that clock samples its data bit.

All channel logic runs on the system clock. The modulator clocks and data pass through two-flop synchronizers, and an edge detector turns the chosen clock edge into a sample enable.

After a programmed number of sampling edges, a channel copies one chosen integrator stage into its 28-bit shadow register and raises its ready flag. A processor reaches the channels through one select window. Through that window it can:
- re-initialise the selected channel;
- gate every channel with one enable bit;
- read the selected channel's ready flag and shadow data;
- clear that flag with a write-one strobe.

Top module: `sd_integ_bank`

## Requirements
- R1: After reset every channel's ready flag and shadow data read as 0.
- R2: On each sampling edge of an enabled channel, the stages update from their old values. Stage 1 adds the data bit (0 or 1), stage 2 adds the old stage 1, and stage 3 adds the old stage 2. All stages wrap modulo 2^28.
- R3: The 2-bit clock-source field of a channel is the index (0 to 3) of the `mod_clk` input it follows. The channel's invert bit set to 0 samples on the rising edge of that input, and set to 1 samples on the falling edge.
- R4: A channel captures on every N-th sampling edge, where N is its 8-bit sample size and a size of 0 means 256. A capture loads the shadow register with the new value of the chosen stage and sets the channel's ready flag.
- R5: A pulse on `reinit` clears the integrators, sample counter, shadow register and ready flag of the selected channel only. All other channels are left as they were.
- R6: While `ch_en` is 0, sampling edges are ignored: no stage, counter, shadow register or flag changes.
- R7: A pulse on `flag_clr` clears only the selected channel's ready flag, and `flag_clr` held at 0 changes nothing. A capture in the same cycle as the clear leaves the flag set.
- R8: `rd_flag` and `rd_data` show the channel selected by `ch_sel` in the previous cycle. A selection of 9 to 15 reads as 0. `reinit` and `flag_clr` act on that same registered selection.
- R9: The 2-bit stage field picks the captured stage: 0 selects stage 1, 1 selects stage 2, and 2 or 3 select stage 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_clk | input | 4 | Modulator clock inputs |
| mod_dat | input | 9 | Modulator data bit per channel |
| cfg_src | input | 18 | Clock-source index, 2 bits per channel |
| cfg_inv | input | 9 | Falling-edge sampling per channel |
| cfg_stage | input | 18 | Captured-stage select, 2 bits per channel |
| cfg_size | input | 72 | Sample size, 8 bits per channel |
| ch_sel | input | 4 | Channel select for the window |
| reinit | input | 1 | Re-initialise the selected channel |
| ch_en | input | 1 | Global channel enable |
| flag_clr | input | 1 | Clear the selected channel's ready flag |
| rd_data | output | 28 | Shadow data of the selected channel |
| rd_flag | output | 1 | Ready flag of the selected channel |

## Verification
A modulator clock toggle takes effect on the third system clock edge after it is applied: two synchronizer flops, then the integrator register. A changed `ch_sel` shows at the read outputs after one edge. The bench therefore holds data stable for four cycles before each toggle and waits five cycles after it. It samples the read window one full cycle after each select change, at the falling edge, so every compared value has settled. Each strobe is issued only after the select has been registered.

// File: rtl/sd_integ_bank.sv
module sd_integ_bank #(
  parameter int NCH  = 9,
  parameter int SRCW = 2,
  parameter int W    = 28,
  parameter int SSW  = 8,
  parameter int SELW = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [(1<<SRCW)-1:0] mod_clk,
  input  logic [NCH-1:0]      mod_dat,
  input  logic [NCH*SRCW-1:0] cfg_src,
  input  logic [NCH-1:0]      cfg_inv,
  input  logic [NCH*2-1:0]    cfg_stage,
  input  logic [NCH*SSW-1:0]  cfg_size,
  input  logic [SELW-1:0]     ch_sel,
  input  logic                reinit,
  input  logic                ch_en,
  input  logic                flag_clr,
  output logic [W-1:0]        rd_data,
  output logic                rd_flag
);
  localparam int NSRC = 1 << SRCW;
  localparam logic [SSW:0] FULL = (SSW+1)'(1) << SSW;

  logic [NSRC-1:0] ck1, ck2, ck3;
  logic [NCH-1:0]  dt1, dt2;
  logic [SELW-1:0] sel_q;
  logic [NCH-1:0]  flag, cap;
  logic [W-1:0]    shd [NCH];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ck1 <= '0; ck2 <= '0; ck3 <= '0;
      dt1 <= '0; dt2 <= '0;
      sel_q <= '0;
    end else begin
      ck1 <= mod_clk; ck2 <= ck1; ck3 <= ck2;
      dt1 <= mod_dat; dt2 <= dt1;
      sel_q <= ch_sel;
    end

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    logic [SRCW-1:0] src;
    logic            lvl, prv, smp, kill, hit;
    logic [SSW:0]    cnt, nxt, tgt;
    logic [W-1:0]    i1, i2, i3, n1, n2, n3, pick;

    assign src  = cfg_src[k*SRCW +: SRCW];
    assign lvl  = ck2[src];
    assign prv  = ck3[src];
    assign smp  = ch_en && (cfg_inv[k] ? (prv && !lvl) : (lvl && !prv));
    assign kill = reinit && (sel_q == SELW'(k));
    assign tgt  = (cfg_size[k*SSW +: SSW] == '0) ? FULL : {1'b0, cfg_size[k*SSW +: SSW]};
    assign nxt  = cnt + 1'b1;
    assign hit  = smp && (nxt == tgt);
    assign cap[k] = hit && !kill;

    assign n1 = i1 + {{(W-1){1'b0}}, dt2[k]};
    assign n2 = i2 + i1;
    assign n3 = i3 + i2;

    always_comb
      case (cfg_stage[k*2 +: 2])
        2'd0:    pick = n1;
        2'd1:    pick = n2;
        default: pick = n3;
      endcase

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        i1 <= '0; i2 <= '0; i3 <= '0; cnt <= '0;
        shd[k] <= '0; flag[k] <= 1'b0;
      end else if (kill) begin
        i1 <= '0; i2 <= '0; i3 <= '0; cnt <= '0;
        shd[k] <= '0; flag[k] <= 1'b0;
      end else begin
        if (smp) begin
          i1  <= n1;
          i2  <= n2;
          i3  <= n3;
          cnt <= hit ? '0 : nxt;
        end
        if (hit) begin
          shd[k]  <= pick;
          flag[k] <= 1'b1;
        end else if (flag_clr && sel_q == SELW'(k)) begin
          flag[k] <= 1'b0;
        end
      end
  end

  assign rd_flag = (sel_q < SELW'(NCH)) ? flag[sel_q] : 1'b0;
  assign rd_data = (sel_q < SELW'(NCH)) ? shd[sel_q] : '0;
endmodule

module sd_integ_bank_chk #(
  parameter int NCH  = 9,
  parameter int W    = 28,
  parameter int SELW = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [SELW-1:0] ch_sel,
  input logic [SELW-1:0] sel_q,
  input logic            reinit,
  input logic            ch_en,
  input logic            flag_clr,
  input logic [NCH-1:0]  flag,
  input logic [NCH-1:0]  cap,
  input logic [W-1:0]    rd_data,
  input logic            rd_flag
);
  assert_out_of_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_sel >= SELW'(NCH)) |=> (!rd_flag && rd_data == '0));

  for (genvar k = 0; k < NCH; k++) begin : g_a
    assert_capture_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cap[k] |=> flag[k]);
    assert_reinit_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (reinit && sel_q == SELW'(k)) |=> !flag[k]);
    assert_disabled_no_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_en |=> !(flag[k] && !$past(flag[k])));
    assert_clear_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr && sel_q == SELW'(k) && !cap[k]) |=> !flag[k]);
  end
endmodule

bind sd_integ_bank sd_integ_bank_chk #(.NCH(NCH), .W(W), .SELW(SELW)) chk_i (
  .clk(clk), .rst_n(rst_n), .ch_sel(ch_sel), .sel_q(sel_q), .reinit(reinit),
  .ch_en(ch_en), .flag_clr(flag_clr), .flag(flag), .cap(cap),
  .rd_data(rd_data), .rd_flag(rd_flag));

// File: tb/sd_integ_bank_tb_top.sv
`timescale 1ns/1ps
module sd_integ_bank_tb_top;
  localparam int NCH = 9;
  localparam int W   = 28;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] mod_clk = '0;
  logic [NCH-1:0] mod_dat = '0;
  logic [NCH*2-1:0] cfg_src = '0, cfg_stage = '0;
  logic [NCH-1:0] cfg_inv = '0;
  logic [NCH*8-1:0] cfg_size = '0;
  logic [3:0] ch_sel = '0;
  logic reinit = 1'b0, ch_en = 1'b0, flag_clr = 1'b0;
  logic [W-1:0] rd_data;
  logic rd_flag;

  sd_integ_bank dut_i (.clk(clk), .rst_n(rst_n), .mod_clk(mod_clk), .mod_dat(mod_dat),
    .cfg_src(cfg_src), .cfg_inv(cfg_inv), .cfg_stage(cfg_stage), .cfg_size(cfg_size),
    .ch_sel(ch_sel), .reinit(reinit), .ch_en(ch_en), .flag_clr(flag_clr),
    .rd_data(rd_data), .rd_flag(rd_flag));

  always #2.5 clk = ~clk;

  int nvec = 0, nbad = 0;
  bit force_one = 0;
  logic [1:0] b_src [NCH], b_stage [NCH];
  bit b_inv [NCH];
  logic [7:0] b_size [NCH];
  logic [W-1:0] m1 [NCH], m2 [NCH], m3 [NCH], mshd [NCH];
  bit mflag [NCH];
  int mcnt [NCH];
  string lab [NCH];

  function automatic logic [W-1:0] stage_of(int c, logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] d);
    return (b_stage[c] == 2'd0) ? a : (b_stage[c] == 2'd1) ? b : d;
  endfunction

  function automatic int target(int c);
    return (b_size[c] == 8'd0) ? 256 : int'(b_size[c]);
  endfunction

  task automatic model_edge(int c, logic v);
    logic [W-1:0] a, b, d;
    if (!ch_en) return;
    if (b_inv[c] ? v : !v) return;
    a = m1[c] + {{(W-1){1'b0}}, mod_dat[c]};
    b = m2[c] + m1[c];
    d = m3[c] + m2[c];
    m1[c] = a; m2[c] = b; m3[c] = d;
    mcnt[c]++;
    if (mcnt[c] == target(c)) begin
      mcnt[c] = 0;
      mshd[c] = stage_of(c, a, b, d);
      mflag[c] = 1;
    end
  endtask

  task automatic model_zero(int c);
    m1[c] = '0; m2[c] = '0; m3[c] = '0; mshd[c] = '0; mflag[c] = 0; mcnt[c] = 0;
  endtask

  task automatic check(string tag, logic [W:0] act, logic [W:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic toggle(int s);
    for (int c = 0; c < NCH; c++)
      mod_dat[c] = (force_one && c == 8) ? 1'b1 : 1'($urandom_range(0, 1));
    repeat (4) @(negedge clk);
    mod_clk[s] = ~mod_clk[s];
    for (int c = 0; c < NCH; c++)
      if (int'(b_src[c]) == s) model_edge(c, mod_clk[s]);
    repeat (5) @(negedge clk);
  endtask

  task automatic look(int c, string tag);
    ch_sel = 4'(c);
    @(negedge clk);
    check({tag, " flag"}, {{W{1'b0}}, rd_flag}, {{W{1'b0}}, mflag[c]});
    check({tag, " data"}, {1'b0, rd_data}, {1'b0, mshd[c]});
  endtask

  task automatic strobe_clr(int c);
    ch_sel = 4'(c);
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
    mflag[c] = 0;
  endtask

  task automatic strobe_reinit(int c);
    ch_sel = 4'(c);
    @(negedge clk); reinit = 1'b1;
    @(negedge clk); reinit = 1'b0;
    model_zero(c);
  endtask

  task automatic finish_up();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    nbad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    void'($urandom(32'd7));
    for (int c = 0; c < NCH; c++) begin
      b_src[c] = 2'($urandom_range(0, 2));
      b_inv[c] = 1'($urandom_range(0, 1));
      b_stage[c] = 2'($urandom_range(0, 3));
      b_size[c] = 8'($urandom_range(1, 12));
      lab[c] = "R2";
      model_zero(c);
    end
    // R3: ch0 rising, ch1 falling on the same source
    b_src[0] = 2'd0; b_inv[0] = 0; b_stage[0] = 2'd2; b_size[0] = 8'd4; lab[0] = "R3";
    b_src[1] = 2'd0; b_inv[1] = 1; b_stage[1] = 2'd2; b_size[1] = 8'd4; lab[1] = "R3";
    // R4: size 0 means 256 edges
    b_src[2] = 2'd1; b_inv[2] = 0; b_stage[2] = 2'd1; b_size[2] = 8'd0; lab[2] = "R4";
    // R9: stage encodings 0 and 3
    b_stage[3] = 2'd0; lab[3] = "R9";
    b_stage[4] = 2'd3; lab[4] = "R9";
    // R2 wrap channel
    b_src[8] = 2'd3; b_inv[8] = 0; b_stage[8] = 2'd2; b_size[8] = 8'd0;
    for (int c = 0; c < NCH; c++) begin
      cfg_src[c*2 +: 2] = b_src[c];
      cfg_inv[c] = b_inv[c];
      cfg_stage[c*2 +: 2] = b_stage[c];
      cfg_size[c*8 +: 8] = b_size[c];
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    for (int c = 0; c < NCH; c++) look(c, "R1");

    for (int c = 0; c < NCH; c++) strobe_reinit(c);
    ch_en = 1'b1;

    for (int it = 0; it < 600; it++) begin
      toggle($urandom_range(0, 2));
      if (it % 40 == 39)
        for (int c = 0; c < NCH; c++) begin
          look(c, lab[c]);
          if (mflag[c] && $urandom_range(0, 1) == 1) strobe_clr(c);
        end
    end

    ch_en = 1'b0;
    for (int it = 0; it < 40; it++) toggle($urandom_range(0, 3));
    for (int c = 0; c < NCH; c++) look(c, "R6");
    ch_en = 1'b1;

    for (int it = 0; it < 20 && !mflag[0]; it++) toggle(0);
    look(0, "R7");
    ch_sel = 4'd5;
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
    mflag[5] = 0;
    look(0, "R7");
    ch_sel = 4'd0;
    repeat (3) @(negedge clk);
    look(0, "R7");
    strobe_clr(0);
    look(0, "R7");

    for (int it = 0; it < 30; it++) toggle($urandom_range(0, 2));
    strobe_reinit(3);
    look(3, "R5");
    look(4, "R5");
    look(0, "R5");

    ch_sel = 4'd12;
    @(negedge clk);
    check("R8 flag", {{W{1'b0}}, rd_flag}, '0);
    check("R8 data", {1'b0, rd_data}, '0);
    ch_sel = 4'd1;
    @(negedge clk);
    check("R8 data", {1'b0, rd_data}, {1'b0, mshd[1]});

    force_one = 1;
    for (int it = 0; it < 2600; it++) toggle(3);
    look(8, "R2");
    for (int c = 0; c < NCH; c++) look(c, lab[c]);

    finish_up();
  end
endmodule